// File: doc/BRIEF.md
# Open-Drain DDC Line Control Register

A 32-bit register that lets software bit-bang a two-wire display data channel by hand. It has an output-enable bit and a drive-value bit for each of the clock line and the data line. Each line is open-drain. A line is pulled low only while its enable is set and its value bit is zero. In every other case the line is released and the bus pull-up holds it high. The two pad levels come back through two readback bits, so software sees the wired-AND of its own drive and of any target on the bus. The bus protocol itself, including start, stop, acknowledge and EDID byte transfers, is left to software.

The lines are not driven continuously from the register. They change only on an *update*. An update latches the new drive state onto the lines, clears bits 11:8 of the register, and starts a short settle count. When the count ends, the synchronised pad levels are loaded into the readback bits. A parameter moves every field by a base bit.

A second parameter selects the update rule:
- In the plain variant, every write is an update.
- In the lane-gated variant, a byte-lane write updates the lines only when a mask bit allows it. This lets software build the register over several narrow writes without glitching the bus.

Top module: `ddc_gpio_reg`

## Requirements
- R1: After reset the register reads 0 and both line outputs are released (scl_low_o = sda_low_o = 0).
- R2: On an update, the clock line is pulled low exactly when bit BASE_BIT+17 (enable) is 1 and bit BASE_BIT+1 (value) is 0. Otherwise it is released. It holds that state until the next update.
- R3: On an update, the data line is pulled low exactly when bit BASE_BIT+16 (enable) is 1 and bit BASE_BIT+0 (value) is 0. Otherwise it is released.
- R4: An update stores the written value with bits 11:8 forced to 0. SETTLE_CYC clock edges after the update edge (4 by default), the synchronised clock-line level is loaded into bit BASE_BIT+9 and the data-line level into bit BASE_BIT+8.
- R5: The readback bits show the wired-AND of the bus. A target holding a line low reads back as 0 even when the host has released that line.
- R6: Plain variant (GATE = GATE_NONE, BASE_BIT = 0): every write is an update, whichever byte lanes it enables.
- R7: Lane-gated variant (GATE = GATE_MASKED, BASE_BIT = 1): a write is an update only when two conditions hold for the merged value. First, bit 25 (mask) is set. Second, either byte lane 2 is written, or lane 0 is written while at least one enable bit is set.
- R8: In the lane-gated variant, a write that is not an update still merges its byte lanes into the register, including bits 11:8. It leaves both line outputs and the readback bits untouched.
- R9: Every write replaces only the bytes whose wr_be_i bit is 1. rd_data_o always shows the stored register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| wr_be_i | input | 4 | Byte-lane enables of the write |
| wr_data_i | input | 32 | Write data |
| rd_data_o | output | 32 | Register contents |
| scl_i | input | 1 | Clock pad level |
| sda_i | input | 1 | Data pad level |
| scl_low_o | output | 1 | Clock pad drive-low enable |
| sda_low_o | output | 1 | Data pad drive-low enable |

## Verification
The hardest case to reach is a lane-gated write that must not update, even though the register ends up holding set enable bits. There are three forms of it: the mask is still clear, only lane 3 is written, or lane 0 is written while both enables are clear. To reach each one, the bench builds the register over a chain of single-lane writes. Before the final write it releases the target pull on the clock line. A wrongly taken update would then reload bit 10 with a visibly different level. A pad-model target that holds one line low while the host releases it exercises the wired-AND readback.

// File: rtl/ddc_gpio_pkg.sv
package ddc_gpio_pkg;
  typedef enum logic {GATE_NONE = 1'b0, GATE_MASKED = 1'b1} gate_mode_e;

  function automatic logic [31:0] merge_lanes(input logic [31:0] cur,
                                              input logic [31:0] wdat,
                                              input logic [3:0]  be);
    logic [31:0] r;
    r = cur;
    for (int i = 0; i < 4; i++)
      if (be[i]) r[i*8 +: 8] = wdat[i*8 +: 8];
    return r;
  endfunction
endpackage

// File: rtl/ddc_pad_sync.sv
module ddc_pad_sync #(
  parameter int STAGES = 2,
  parameter int W      = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] chain_q [STAGES];

  // idle bus is high
  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) chain_q[0] <= '1;
    else         chain_q[0] <= d_i;

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni)
      if (!rst_ni) chain_q[s] <= '1;
      else         chain_q[s] <= chain_q[s-1];
  end

  assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/ddc_upd_ctrl.sv
module ddc_upd_ctrl
  import ddc_gpio_pkg::*;
#(
  parameter gate_mode_e GATE     = GATE_NONE,
  parameter int         MASK_BIT = 25,
  parameter int         SCL_EN   = 17,
  parameter int         SDA_EN   = 16
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        wr_en_i,
  input  logic [3:0]  wr_be_i,
  input  logic [31:0] merged_i,
  output logic        upd_o
);
  if (GATE == GATE_MASKED) begin : g_masked
    logic lane_hit;
    assign lane_hit = wr_be_i[2] ||
                      (wr_be_i[0] && (merged_i[SCL_EN] || merged_i[SDA_EN]));
    assign upd_o = wr_en_i && merged_i[MASK_BIT] && lane_hit;

    // R7
    upd_needs_mask_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      upd_o |-> (wr_en_i && merged_i[MASK_BIT] && (wr_be_i[2] || wr_be_i[0])));
  end else begin : g_plain
    assign upd_o = wr_en_i;

    // R6
    every_write_upd_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      wr_en_i |-> upd_o);
  end
endmodule

// File: rtl/ddc_line_drv.sv
module ddc_line_drv #(
  parameter int SCL_EN  = 17,
  parameter int SCL_VAL = 1,
  parameter int SDA_EN  = 16,
  parameter int SDA_VAL = 0
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        upd_i,
  input  logic [31:0] val_i,
  output logic        scl_low_o,
  output logic        sda_low_o
);
  logic scl_low_q, sda_low_q;

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) begin
      scl_low_q <= 1'b0;
      sda_low_q <= 1'b0;
    end else if (upd_i) begin
      scl_low_q <= val_i[SCL_EN] & ~val_i[SCL_VAL];
      sda_low_q <= val_i[SDA_EN] & ~val_i[SDA_VAL];
    end

  assign scl_low_o = scl_low_q;
  assign sda_low_o = sda_low_q;

  // R2
  scl_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(scl_low_q) |-> $past(upd_i));
  // R3
  sda_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(sda_low_q) |-> $past(upd_i));
endmodule

// File: rtl/ddc_gpio_reg.sv
module ddc_gpio_reg
  import ddc_gpio_pkg::*;
#(
  parameter int         BASE_BIT    = 0,
  parameter gate_mode_e GATE        = GATE_NONE,
  parameter int         MASK_BIT    = 25,
  parameter int         SETTLE_CYC  = 4,
  parameter int         SYNC_STAGES = 2
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        wr_en_i,
  input  logic [3:0]  wr_be_i,
  input  logic [31:0] wr_data_i,
  output logic [31:0] rd_data_o,
  input  logic        scl_i,
  input  logic        sda_i,
  output logic        scl_low_o,
  output logic        sda_low_o
);
  localparam int SDA_VAL = BASE_BIT;
  localparam int SCL_VAL = BASE_BIT + 1;
  localparam int SDA_RB  = BASE_BIT + 8;
  localparam int SCL_RB  = BASE_BIT + 9;
  localparam int SDA_EN  = BASE_BIT + 16;
  localparam int SCL_EN  = BASE_BIT + 17;
  localparam int CNT_W   = $clog2(SETTLE_CYC + 1);

  logic [31:0]      reg_q, reg_d, merged;
  logic [CNT_W-1:0] cnt_q;
  logic             upd, cap;
  logic [1:0]       pad_s;   // {scl, sda}

  assign merged = merge_lanes(reg_q, wr_data_i, wr_be_i);

  ddc_upd_ctrl #(
    .GATE(GATE), .MASK_BIT(MASK_BIT), .SCL_EN(SCL_EN), .SDA_EN(SDA_EN)
  ) u_upd (
    .clk_i(clk_i), .rst_ni(rst_ni), .wr_en_i(wr_en_i), .wr_be_i(wr_be_i),
    .merged_i(merged), .upd_o(upd)
  );

  ddc_line_drv #(
    .SCL_EN(SCL_EN), .SCL_VAL(SCL_VAL), .SDA_EN(SDA_EN), .SDA_VAL(SDA_VAL)
  ) u_drv (
    .clk_i(clk_i), .rst_ni(rst_ni), .upd_i(upd), .val_i(merged),
    .scl_low_o(scl_low_o), .sda_low_o(sda_low_o)
  );

  ddc_pad_sync #(.STAGES(SYNC_STAGES), .W(2)) u_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i({scl_i, sda_i}), .q_o(pad_s)
  );

  // settle counter: a new update restarts it
  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni)             cnt_q <= '0;
    else if (upd)            cnt_q <= CNT_W'(SETTLE_CYC);
    else if (cnt_q != '0)    cnt_q <= cnt_q - CNT_W'(1);

  assign cap = (cnt_q == CNT_W'(1)) && !upd;

  always_comb begin
    reg_d = reg_q;
    if (wr_en_i) begin
      reg_d = merged;
      if (upd) reg_d[11:8] = 4'h0;
    end
    if (cap) begin
      reg_d[SCL_RB] = pad_s[1];
      reg_d[SDA_RB] = pad_s[0];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) reg_q <= '0;
    else         reg_q <= reg_d;

  assign rd_data_o = reg_q;

  // R4
  upd_clears_rb_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    upd |=> (reg_q[11:8] == 4'h0));
  // R4
  cap_loads_pads_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cap && !wr_en_i) |=> (reg_q[SCL_RB] == $past(pad_s[1]) &&
                           reg_q[SDA_RB] == $past(pad_s[0])));
  // R8
  no_upd_lines_stable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && !upd) |=> ($stable(scl_low_o) && $stable(sda_low_o)));
endmodule

// File: tb/ddc_gpio_reg_tb.sv
module ddc_gpio_reg_tb;
  import ddc_gpio_pkg::*;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        wr_a = 1'b0, wr_b = 1'b0;
  logic [3:0]  be = 4'h0;
  logic [31:0] wdat = '0;
  logic        tgt_scl = 1'b0, tgt_sda = 1'b0;
  logic [31:0] rd_a, rd_b;
  logic        scl_low_a, sda_low_a, scl_low_b, sda_low_b;
  logic        scl_a, sda_a, scl_b, sda_b;
  int          n_chk = 0, n_fail = 0;
  logic        done = 1'b0;

  always #5 clk = ~clk;

  // open-drain bus with pull-up and a target that may pull low
  assign scl_a = ~(scl_low_a | tgt_scl);
  assign sda_a = ~(sda_low_a | tgt_sda);
  assign scl_b = ~(scl_low_b | tgt_scl);
  assign sda_b = ~(sda_low_b | tgt_sda);

  ddc_gpio_reg #(.BASE_BIT(0), .GATE(GATE_NONE)) u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .wr_en_i(wr_a), .wr_be_i(be),
    .wr_data_i(wdat), .rd_data_o(rd_a), .scl_i(scl_a), .sda_i(sda_a),
    .scl_low_o(scl_low_a), .sda_low_o(sda_low_a)
  );

  ddc_gpio_reg #(.BASE_BIT(1), .GATE(GATE_MASKED)) u_dut_gate (
    .clk_i(clk), .rst_ni(rst_ni), .wr_en_i(wr_b), .wr_be_i(be),
    .wr_data_i(wdat), .rd_data_o(rd_b), .scl_i(scl_b), .sda_i(sda_b),
    .scl_low_o(scl_low_b), .sda_low_o(sda_low_b)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  // drive at negedge, strobe one edge, return at the following negedge
  task automatic wr(input bit gated, input logic [3:0] b, input logic [31:0] d);
    @(negedge clk);
    be = b; wdat = d;
    if (gated) wr_b = 1'b1; else wr_a = 1'b1;
    @(negedge clk);
    wr_a = 1'b0; wr_b = 1'b0;
  endtask

  task automatic settle();
    repeat (6) @(negedge clk);
  endtask

  task automatic t_reset();
    chk("R1 plain reg", rd_a, 32'h0);
    chk("R1 plain lines", {30'h0, scl_low_a, sda_low_a}, 32'h0);
    chk("R1 gated reg", rd_b, 32'h0);
    chk("R1 gated lines", {30'h0, scl_low_b, sda_low_b}, 32'h0);
  endtask

  task automatic t_plain_drive();
    wr(1'b0, 4'hF, 32'h0003_0003);
    chk("R2 R3 released", {30'h0, scl_low_a, sda_low_a}, 32'h0);
    settle();
    chk("R4 readback high", rd_a, 32'h0003_0303);
    wr(1'b0, 4'hF, 32'h0003_0000);
    chk("R2 R3 both low", {30'h0, scl_low_a, sda_low_a}, 32'h3);
    settle();
    chk("R4 readback low", rd_a, 32'h0003_0000);
    wr(1'b0, 4'hF, 32'h0002_0000);  // clock enabled low, data released
    chk("R2 R3 scl only", {30'h0, scl_low_a, sda_low_a}, 32'h2);
    settle();
    chk("R4 scl low sda high", rd_a, 32'h0002_0100);
  endtask

  task automatic t_plain_target();
    tgt_sda = 1'b1;
    wr(1'b0, 4'hF, 32'h0003_0003);
    settle();
    chk("R5 target holds sda", rd_a, 32'h0003_0203);
    tgt_sda = 1'b0;
  endtask

  task automatic t_plain_lanes();
    wr(1'b0, 4'hF, 32'h0003_0F00);    // software bits 11:8 overwritten
    chk("R4 clear on update", {28'h0, rd_a[11:8]}, 32'h0);
    chk("R2 R3 en low val low", {30'h0, scl_low_a, sda_low_a}, 32'h3);
    wr(1'b0, 4'h4, 32'h0000_0000);    // lane 2 only, still an update
    chk("R6 lane2 updates", {30'h0, scl_low_a, sda_low_a}, 32'h0);
    settle();
    chk("R9 R6 merged", rd_a, 32'h0000_0300);
  endtask

  task automatic t_gated();
    wr(1'b1, 4'h4, 32'h0006_0000);    // enables, mask clear
    chk("R8 mask clear lines", {30'h0, scl_low_b, sda_low_b}, 32'h0);
    settle();
    chk("R8 R9 mask clear reg", rd_b, 32'h0006_0000);
    wr(1'b1, 4'h8, 32'h0200_0000);    // mask via lane 3 only
    settle();
    chk("R7 lane3 no update", {rd_b[31:2], scl_low_b, sda_low_b}, 32'h0206_0000);
    wr(1'b1, 4'h1, 32'h0000_0000);    // lane 0 with enables and mask
    chk("R7 R2 R3 lane0 update", {30'h0, scl_low_b, sda_low_b}, 32'h3);
    settle();
    chk("R7 R4 readback low", rd_b, 32'h0206_0000);
    wr(1'b1, 4'h1, 32'h0000_0006);
    chk("R2 R3 gated released", {30'h0, scl_low_b, sda_low_b}, 32'h0);
    settle();
    chk("R4 gated readback", rd_b, 32'h0206_0606);
    tgt_scl = 1'b1;
    wr(1'b1, 4'h4, 32'h0006_0000);    // lane 2 update
    settle();
    chk("R5 R7 target scl", rd_b, 32'h0206_0206);
    tgt_scl = 1'b0;
    wr(1'b1, 4'h8, 32'h0000_0000);    // mask off
    wr(1'b1, 4'h1, 32'h0000_0000);    // would pull both low if taken
    chk("R8 mask off lines", {30'h0, scl_low_b, sda_low_b}, 32'h0);
    settle();
    chk("R8 mask off reg", rd_b, 32'h0006_0200);
    wr(1'b1, 4'h4, 32'h0000_0000);    // enables cleared, mask off
    wr(1'b1, 4'h8, 32'h0200_0000);
    wr(1'b1, 4'h1, 32'h0000_0000);    // lane 0, mask set, enables clear
    settle();
    chk("R7 lane0 no enable", rd_b, 32'h0200_0200);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    t_reset();
    t_plain_drive();
    t_plain_target();
    t_plain_lanes();
    t_gated();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule